// File: doc/BRIEF.md
# Wake-and-Acknowledge Watchdog Timer

This block supervises a host processor with a repeating timer. At the end of every programmed interval it raises a WAKE pulse, and the host must answer with a DONE pulse of at least a minimum width before the following interval ends. If that answer is missing, the block pulls its active-low reset output low for a fixed number of cycles. After the reset ends, a new interval starts with no acknowledge owed.

The DONE input is synchronized and qualified on-chip. Only the first qualified DONE in an interval is counted. Any further pulses are absorbed and leave the interval timing unchanged. A DONE pulse whose first synchronized high cycle falls inside a guard window around the interval boundary is rejected as ambiguous. The rejection follows a fixed rule, and a later, clean pulse in the same interval is still accepted. A manual-reset input pulls the reset output low no matter what state the interval is in.

Top module: `wake_ack_watchdog`

## Requirements
- R1: While the power-on reset input is low, WAKE is 0 and RSTn is 1. After release, the interval counter restarts and all acknowledge state is cleared. The first WAKE rises between L+1 and L+3 cycles after release, where L is `interval_len_i`, and no reset is raised at that first WAKE.
- R2: WAKE rises exactly once every L cycles and stays high for WAKE_CYC cycles. This holds whether or not DONE was received. The configuration must satisfy L > 2*GUARD_CYC + WAKE_CYC.
- R3: If an interval that follows a WAKE ends without a valid DONE, RSTn falls in the same cycle that the next WAKE rises and stays low for exactly RST_CYC cycles.
- R4: DONE passes through a two-flop synchronizer. A DONE pulse that is high for at least MIN_CYC cycles is valid, and a valid DONE prevents the reset at the end of its interval.
- R5: A DONE pulse that is high for fewer than MIN_CYC cycles is ignored. It does not prevent the reset.
- R6: Only the first valid DONE in an interval is counted. Extra DONE pulses leave the WAKE period unchanged and give no credit to the next interval.
- R7: A DONE pulse is ignored if its first synchronized high cycle occurs while the interval count is below GUARD_CYC or at or above L-GUARD_CYC. A later valid DONE in the same interval is still accepted.
- R8: While the manual-reset input is high, RSTn goes low within 3 cycles and stays low. After the input returns low, RSTn returns high exactly RST_CYC+2 cycles later.
- R9: After RSTn returns high, the next WAKE rises exactly L cycles later, and that WAKE does not cause a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low; asserts asynchronously and is released synchronously |
| done_i | input | 1 | Acknowledge pulse from the host, asynchronous |
| mr_i | input | 1 | Manual reset request, active high, asynchronous |
| interval_len_i | input | CNT_W | Interval length L in cycles |
| wake_o | output | 1 | Interval-end pulse to the host |
| rstn_o | output | 1 | Supervisory reset to the host, active low |

## Verification
Every result follows its cause by a fixed number of clock edges. A DONE change takes two edges to pass the synchronizer and MIN_CYC more to qualify. A WAKE rise and its paired RSTn fall appear together one edge after the terminal count. RSTn returns high RST_CYC edges after it falls, or RST_CYC+2 edges after the manual reset is released. The next WAKE follows L edges after that. The bench keeps a free-running edge count and logs every output transition at the falling clock edge. It then compares the differences between logged edges against these exact counts. The only exception is the release of the power-on reset, where a one-cycle tolerance covers the reset synchronizer. Guard-window stimulus is launched from the falling edge where WAKE is first seen high. This places the pulse's first synchronized high cycle at interval count 2, which lies inside the guard window.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Flags the interval timer hands to the top level.
  typedef struct packed {
    logic fire;      // interval ended while an acknowledge was still owed
    logic in_guard;  // count lies near an interval boundary
  } ivl_flags_t;

  // Bits needed to hold the value n.
  function automatic int unsigned cnt_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= d_i[g];
        sync_q[g] <= meta_q[g];
      end
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/wdog_done_qual.sv
module wdog_done_qual
  import wdog_pkg::*;
#(
  parameter int unsigned MIN_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic done_s_i,
  input  logic in_guard_i,
  output logic accept_o
);

  localparam int unsigned RUN_W = cnt_bits(MIN_CYC);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_CYC);
  localparam logic [RUN_W-1:0] RUN_HIT = RUN_W'(MIN_CYC - 1);

  logic [RUN_W-1:0] run_q, run_d;
  logic             ok_q, ok_d;
  logic             first_hi;
  logic             pulse_ok;

  // The first high cycle of a pulse decides whether the pulse may count.
  assign first_hi = done_s_i && (run_q == '0);
  assign pulse_ok = first_hi ? !in_guard_i : ok_q;
  assign accept_o = en_i && done_s_i && (run_q == RUN_HIT) && pulse_ok;

  always_comb begin
    run_d = run_q;
    ok_d  = ok_q;
    if (!done_s_i) begin
      run_d = '0;
      ok_d  = 1'b0;
    end else begin
      if (run_q != RUN_MAX) begin
        run_d = run_q + RUN_W'(1);
      end
      ok_d = pulse_ok;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      run_q <= run_d;
      ok_q  <= ok_d;
    end
  end

  // R6: one qualified pulse yields a single accept event
  p_accept_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !accept_o);

endmodule

// File: rtl/wdog_interval.sv
module wdog_interval
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned WAKE_CYC  = 4,
  parameter int unsigned GUARD_CYC = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             accept_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             wake_o,
  output ivl_flags_t       flags_o
);

  localparam int unsigned WK_W = cnt_bits(WAKE_CYC);
  localparam int unsigned EXT_W = CNT_W + 1;
  localparam logic [WK_W-1:0]  WAKE_LD = WK_W'(WAKE_CYC);
  localparam logic [CNT_W-1:0] GUARD_V = CNT_W'(GUARD_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [WK_W-1:0]  wk_q, wk_d;
  logic             armed_q, armed_d;
  logic             acked_q, acked_d;
  logic             term;
  logic [EXT_W-1:0] cnt_ahead;

  assign term      = !hold_i && (cnt_q == (len_i - CNT_W'(1)));
  assign cnt_ahead = {1'b0, cnt_q} + EXT_W'(GUARD_CYC);

  assign flags_o.in_guard = (cnt_q < GUARD_V) || (cnt_ahead >= {1'b0, len_i});
  assign flags_o.fire     = term && armed_q && !(acked_q || accept_i);
  assign wake_o           = (wk_q != '0);

  always_comb begin
    cnt_d   = cnt_q + CNT_W'(1);
    armed_d = armed_q;
    acked_d = acked_q || accept_i;
    wk_d    = wk_q;
    if (wk_q != '0) begin
      wk_d = wk_q - WK_W'(1);
    end
    if (hold_i) begin
      cnt_d   = '0;
      armed_d = 1'b0;
      acked_d = 1'b0;
    end else if (term) begin
      cnt_d   = '0;
      armed_d = 1'b1;
      acked_d = 1'b0;
      wk_d    = WAKE_LD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      wk_q    <= '0;
      armed_q <= 1'b0;
      acked_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      wk_q    <= wk_d;
      armed_q <= armed_d;
      acked_q <= acked_d;
    end
  end

  // R2: the counter restarts at the same edge where WAKE rises
  p_wake_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> (cnt_q == '0));

  // R4: acknowledge is recorded only after the qualifier accepted a pulse
  p_ack_needs_accept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acked_q) |-> $past(accept_i));

endmodule

// File: rtl/wdog_reset_gen.sv
module wdog_reset_gen
  import wdog_pkg::*;
#(
  parameter int unsigned RST_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic mr_s_i,
  output logic active_o
);

  localparam int unsigned RC_W = cnt_bits(RST_CYC);
  localparam logic [RC_W-1:0] RC_LD = RC_W'(RST_CYC);

  logic [RC_W-1:0] rc_q, rc_d;

  always_comb begin
    rc_d = rc_q;
    if (fire_i || mr_s_i) begin
      rc_d = RC_LD;
    end else if (rc_q != '0) begin
      rc_d = rc_q - RC_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rc_q <= '0;
    end else begin
      rc_q <= rc_d;
    end
  end

  assign active_o = (rc_q != '0);

  // R3: a reset pulse lasts more than a single cycle once started
  p_reset_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(active_o) && (RST_CYC > 1)) |=> active_o);

endmodule

// File: rtl/wake_ack_watchdog.sv
module wake_ack_watchdog
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned MIN_CYC   = 5,
  parameter int unsigned GUARD_CYC = 5,
  parameter int unsigned WAKE_CYC  = 4,
  parameter int unsigned RST_CYC   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             mr_i,
  input  logic [CNT_W-1:0] interval_len_i,
  output logic             wake_o,
  output logic             rstn_o
);

  logic       rst_meta_q, rst_sync_q;
  logic       rst_n;
  logic [1:0] async_in, sync_out;
  logic       done_s, mr_s;
  logic       accept;
  logic       rst_act;
  ivl_flags_t flags;

  // Reset: asserts at once, releases on the second clock edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_n = rst_sync_q;

  assign async_in = {mr_i, done_i};

  wdog_sync #(.W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    (async_in),
    .q_o    (sync_out)
  );
  assign done_s = sync_out[0];
  assign mr_s   = sync_out[1];

  wdog_done_qual #(.MIN_CYC(MIN_CYC)) u_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .en_i       (!rst_act),
    .done_s_i   (done_s),
    .in_guard_i (flags.in_guard),
    .accept_o   (accept)
  );

  wdog_interval #(
    .CNT_W     (CNT_W),
    .WAKE_CYC  (WAKE_CYC),
    .GUARD_CYC (GUARD_CYC)
  ) u_ivl (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .hold_i   (rst_act),
    .accept_i (accept),
    .len_i    (interval_len_i),
    .wake_o   (wake_o),
    .flags_o  (flags)
  );

  wdog_reset_gen #(.RST_CYC(RST_CYC)) u_rgen (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .fire_i   (flags.fire),
    .mr_s_i   (mr_s),
    .active_o (rst_act)
  );

  assign rstn_o = !rst_act;

  // R8: a synchronized manual request drives the reset output low
  p_mr_forces_low_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    mr_s |=> !rstn_o);

  // R3: a timeout reset starts together with the WAKE rise
  p_timeout_with_wake_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($fell(rstn_o) && !$past(mr_s)) |-> $rose(wake_o));

endmodule

// File: tb/wake_ack_watchdog_tb_top.sv
module wake_ack_watchdog_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int MINC  = 4;
  localparam int GRD   = 4;
  localparam int WKC   = 3;
  localparam int RSTC  = 6;
  localparam int L     = 40;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             done_i = 1'b0;
  logic             mr_i = 1'b0;
  logic [CNT_W-1:0] interval_len = CNT_W'(L);
  logic             wake_o, rstn_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int cyc = 0;
  int wake_rises = 0, wake_rise_cyc = 0, wake_len = 0;
  int rstn_falls = 0, rstn_fall_cyc = 0, rstn_rise_cyc = 0;
  int rel_cyc = 0;
  logic wake_p = 1'b0, rstn_p = 1'b1;

  wake_ack_watchdog #(
    .CNT_W(CNT_W), .MIN_CYC(MINC), .GUARD_CYC(GRD),
    .WAKE_CYC(WKC), .RST_CYC(RSTC)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .done_i(done_i), .mr_i(mr_i),
    .interval_len_i(interval_len), .wake_o(wake_o), .rstn_o(rstn_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Output event log, sampled mid-cycle.
  always @(negedge clk) begin
    if (wake_o === 1'b1 && wake_p === 1'b0) begin
      wake_rises++;
      wake_rise_cyc = cyc;
    end
    if (wake_o === 1'b0 && wake_p === 1'b1) wake_len = cyc - wake_rise_cyc;
    if (rstn_o === 1'b0 && rstn_p === 1'b1) begin
      rstn_falls++;
      rstn_fall_cyc = cyc;
    end
    if (rstn_o === 1'b1 && rstn_p === 1'b0) rstn_rise_cyc = cyc;
    wake_p = wake_o;
    rstn_p = rstn_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_rise();
    int t;
    t = wake_rises + 1;
    while (wake_rises < t) step();
  endtask

  task automatic pulse_done(input int n);
    done_i = 1'b1;
    repeat (n) step();
    done_i = 1'b0;
  endtask

  task automatic por();
    rst_ni = 1'b0;
    done_i = 1'b0;
    mr_i   = 1'b0;
    repeat (3) step();
    rst_ni = 1'b1;
    rel_cyc = cyc;
  endtask

  // R1: reset state, restart after release, acknowledge state cleared
  task automatic t_reset();
    int f0, d;
    rst_ni = 1'b0;
    repeat (3) step();
    chk(wake_o == 1'b0, "R1 wake low in reset", int'(wake_o), 0);
    chk(rstn_o == 1'b1, "R1 rstn high in reset", int'(rstn_o), 1);
    por();
    f0 = rstn_falls;
    wait_rise();
    d = wake_rise_cyc - rel_cyc;
    chk(d >= L + 1 && d <= L + 3, "R1 first wake delay", d, L + 2);
    repeat (20) step();
    por();
    wait_rise();
    d = wake_rise_cyc - rel_cyc;
    chk(d >= L + 1 && d <= L + 3, "R1 wake delay after mid-interval reset", d, L + 2);
    repeat (3) step();
    chk(rstn_falls == f0, "R1 no reset at first wake after reset", rstn_falls - f0, 0);
  endtask

  // R2, R3, R9: missing acknowledge, reset pulse, fresh interval afterwards
  task automatic t_noack();
    int c1, f0;
    por();
    f0 = rstn_falls;
    wait_rise();
    c1 = wake_rise_cyc;
    wait_rise();
    chk(wake_rise_cyc - c1 == L, "R2 wake period without done", wake_rise_cyc - c1, L);
    chk(rstn_falls == f0 + 1, "R3 reset on missing done", rstn_falls - f0, 1);
    chk(rstn_fall_cyc == wake_rise_cyc, "R3 reset aligned with wake",
        rstn_fall_cyc - wake_rise_cyc, 0);
    while (!rstn_o) step();
    chk(rstn_rise_cyc - rstn_fall_cyc == RSTC, "R3 reset width",
        rstn_rise_cyc - rstn_fall_cyc, RSTC);
    chk(wake_len == WKC, "R2 wake width", wake_len, WKC);
    wait_rise();
    chk(wake_rise_cyc - rstn_rise_cyc == L, "R9 wake after reset release",
        wake_rise_cyc - rstn_rise_cyc, L);
    repeat (3) step();
    chk(rstn_falls == f0 + 1, "R9 no reset at first wake after release",
        rstn_falls - f0, 1);
  endtask

  // R4: valid acknowledges in every interval keep reset away
  task automatic t_valid();
    int f0;
    por();
    f0 = rstn_falls;
    wait_rise();
    for (int i = 0; i < 4; i++) begin
      repeat (10) step();
      pulse_done(MINC);
      wait_rise();
    end
    repeat (3) step();
    chk(rstn_falls == f0, "R4 valid done prevents reset", rstn_falls - f0, 0);
  endtask

  // R5: pulse one cycle short of the minimum
  task automatic t_short();
    int f0;
    por();
    f0 = rstn_falls;
    wait_rise();
    repeat (10) step();
    pulse_done(MINC - 1);
    wait_rise();
    repeat (2) step();
    chk(rstn_falls == f0 + 1, "R5 short done ignored", rstn_falls - f0, 1);
  endtask

  // R6: several pulses in one interval earn no credit for the next
  task automatic t_multi();
    int f0, c1;
    por();
    f0 = rstn_falls;
    wait_rise();
    repeat (5) step();
    for (int i = 0; i < 4; i++) begin
      pulse_done(MINC);
      repeat (3) step();
    end
    wait_rise();
    c1 = wake_rise_cyc;
    repeat (2) step();
    chk(rstn_falls == f0, "R6 first valid done accepted", rstn_falls - f0, 0);
    wait_rise();
    chk(wake_rise_cyc - c1 == L, "R6 period unchanged by extra done",
        wake_rise_cyc - c1, L);
    repeat (2) step();
    chk(rstn_falls == f0 + 1, "R6 no carry into next interval", rstn_falls - f0, 1);
  endtask

  // R7: pulse starting just after WAKE is ignored, later pulse still counts
  task automatic t_guard();
    int f0;
    por();
    f0 = rstn_falls;
    wait_rise();
    pulse_done(MINC + 2);
    wait_rise();
    repeat (2) step();
    chk(rstn_falls == f0 + 1, "R7 guard-window done ignored", rstn_falls - f0, 1);
    por();
    f0 = rstn_falls;
    wait_rise();
    pulse_done(MINC + 2);
    repeat (8) step();
    pulse_done(MINC);
    wait_rise();
    repeat (2) step();
    chk(rstn_falls == f0, "R7 later done accepted after guard", rstn_falls - f0, 0);
  endtask

  // R8: manual reset
  task automatic t_mr();
    int k;
    por();
    wait_rise();
    repeat (5) step();
    mr_i = 1'b1;
    repeat (3) step();
    chk(rstn_o == 1'b0, "R8 manual reset drives rstn low", int'(rstn_o), 0);
    repeat (10) step();
    chk(rstn_o == 1'b0, "R8 rstn held while manual reset high", int'(rstn_o), 0);
    mr_i = 1'b0;
    k = 0;
    while (!rstn_o && k < 100) begin
      step();
      k++;
    end
    chk(k == RSTC + 2, "R8 release delay after manual reset", k, RSTC + 2);
  endtask

  initial begin
    t_reset();
    t_noack();
    t_valid();
    t_short();
    t_multi();
    t_guard();
    t_mr();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule